// File: doc/BRIEF.md
# PIO request region decoder

The block watches a 130-bit request bus that runs from the processor toward the IO side. It keeps a base/mask pair for each of three PCIe address windows: one shared by configuration and IO space, one for 32-bit memory and one for 64-bit memory. These pairs are programmed by write requests that target the block's own register space. Those writes arrive on the same bus as the traffic being decoded.

Each PIO request is checked against the enabled windows. The request becomes a command record with these contents:
- a 4-bit command code
- the full address
- a transfer length (for reads) or a byte mask (for writes)
- the requesting thread ID
- the first data word
- the matching window's base with its enable bit cleared

The record is offered on a valid/ready output. A request that hits no enabled window produces a one-cycle error pulse instead of a record.

Top module: `pio_region_decoder`

## Requirements
- R1: A request is strobed by `req_vld` for one cycle; its payload is on `req_word` during the following cycle. The resulting command (or error pulse) becomes visible two cycles after that payload cycle.
- R2: Request type field (bits 128:124) equal to 0 is a read; any other value is a write. For a read, size field (bits 111:104) codes 0..4 give a length of 1, 2, 4, 8 or 16 bytes, and any other code gives 0. For a write, the size field is passed to `cmd_len` unchanged.
- R3: A write whose address bits 39:32 equal 0x80 updates the register selected by address bits 15:0. The offsets are: 32-bit memory base 0x2000, mask 0x2008; 64-bit memory base 0x2010, mask 0x2018; config/IO base 0x2020, mask 0x2028. Reads to these offsets, and writes with address bits 39:32 equal to 0x88, change nothing.
- R4: After reset all base registers are zero, so every window is disabled and no command is produced.
- R5: A request is a PIO request when address bits 39:36 equal 0xC. A window matches only when its base bit 63 is set and (mask AND address) equals base over the compared bits. The compared bits are 35:24 for both memory windows and 35:29 for the config/IO window.
- R6: In the config/IO window, address bit 28 set selects IO and clear selects config. A config access is type 0 when address bits 27:20 are all zero, and type 1 otherwise.
- R7: When several windows match, 64-bit memory wins over 32-bit memory, which wins over config/IO.
- R8: `cmd_base` is the matching window's base register with bit 63 forced to 0.
- R9: `cmd_code` is {kind, write}. The kind values are: config type 0 = 0, config type 1 = 1, IO = 2, 32-bit memory = 3, 64-bit memory = 4. This gives codes 0..9.
- R10: A PIO request that matches no enabled window raises `nomatch_err` for exactly one cycle and produces no command.
- R11: While `cmd_valid` is high and `cmd_ready` is low, the output record holds steady.
- R12: A decoded command that arrives while the output is stalled is dropped. It raises `overflow_err` for one cycle, and the held record is kept.
- R13: The record carries the request's address, thread ID (bits 122:117) and data (bits 63:0) unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_vld | input | 1 | Request strobe; payload follows one cycle later |
| req_word | input | 130 | Request payload |
| cmd_ready | input | 1 | Consumer accepts the command record |
| cmd_valid | output | 1 | Command record valid |
| cmd_code | output | 4 | Command code {kind, write} |
| cmd_addr | output | 40 | Request address |
| cmd_len | output | 8 | Read length in bytes or write byte mask |
| cmd_tid | output | 6 | Requesting thread ID |
| cmd_data | output | 64 | First data word |
| cmd_base | output | 64 | Matching base register, enable bit cleared |
| nomatch_err | output | 1 | One-cycle pulse: PIO request hit no window |
| overflow_err | output | 1 | One-cycle pulse: command dropped while stalled |

## Verification
The hardest case to reach is a request that several enabled windows match at once, because it needs a particular register state first. The stimulus reprograms the 64-bit and then the 32-bit window with an all-zero mask so that each matches every address. It then sends a config address and disables the windows one by one, so that each step of the priority order is exposed. The overflow case needs the consumer to hold `cmd_ready` low across a whole second request. The bench stalls, checks that the held record stays steady, and then sends a second matching request.

// File: rtl/pio_dec_pkg.sv
// Package: shared field positions, window indices, command codes and the
// command record type for the PIO request region decoder.
// Assumes a 130-bit request word with a 40-bit address and 64-bit data.
package pio_dec_pkg;

    localparam int REQ_W   = 130;
    localparam int ADDR_W  = 40;
    localparam int DATA_W  = 64;
    localparam int TID_W   = 6;
    localparam int SIZE_W  = 8;
    localparam int TYPE_W  = 5;
    localparam int OFF_W   = 16;
    localparam int NUM_WIN = 3;
    localparam int WIN_IW  = 2;

    // Field positions inside the request word
    localparam int TYPE_HI = 128;
    localparam int TID_HI  = 122;
    localparam int SIZE_HI = 111;
    localparam int ADDR_HI = 103;
    localparam int DATA_HI = 63;

    // Window indices; higher index wins on multiple hits
    localparam int WIN_CFGIO = 0;
    localparam int WIN_MEM32 = 1;
    localparam int WIN_MEM64 = 2;

    // Compared address field: bits 35 down to a per-window low bit
    localparam int CMP_HI = 35;

    // Enable bit in each base register
    localparam int EN_BIT = 63;

    typedef enum logic [2:0] {
        KIND_CFG0  = 3'd0,
        KIND_CFG1  = 3'd1,
        KIND_IO    = 3'd2,
        KIND_MEM32 = 3'd3,
        KIND_MEM64 = 3'd4
    } cmd_kind_e;

    typedef struct packed {
        logic [3:0]        code;
        logic [ADDR_W-1:0] addr;
        logic [SIZE_W-1:0] len;
        logic [TID_W-1:0]  tid;
        logic [DATA_W-1:0] data;
        logic [DATA_W-1:0] base;
    } cmd_rec_t;

    // Low bit of the compared field for a window
    function automatic int win_cmp_lo(input int k);
        return (k == WIN_CFGIO) ? 29 : 24;
    endfunction

    // Register offset of a window's base register (mask sits 8 above)
    function automatic logic [OFF_W-1:0] win_base_off(input int k);
        case (k)
            WIN_MEM32: return 16'h2000;
            WIN_MEM64: return 16'h2010;
            default:   return 16'h2020;
        endcase
    endfunction

endpackage

// File: rtl/pio_req_capture.sv
// Capture stage: delays the request strobe by one cycle and registers the
// payload in the cycle after the strobe, where the bus carries it.
// Assumes the payload is only meaningful in that one cycle.
module pio_req_capture #(
    parameter int WORD_W = 130
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_vld,
    input  logic [WORD_W-1:0] req_word,
    output logic              cap_vld,
    output logic [WORD_W-1:0] cap_word
);

    logic strobe_d;

    // Track the strobe into the payload cycle
    always_ff @(posedge clk) begin
        if (!rst_n) strobe_d <= 1'b0;
        else        strobe_d <= req_vld;
    end

    // Register the payload and mark it valid for one cycle
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cap_vld  <= 1'b0;
            cap_word <= '0;
        end else begin
            cap_vld <= strobe_d;
            if (strobe_d) cap_word <= req_word;
        end
    end

endmodule

// File: rtl/pio_window_regs.sv
// Window register file: one base and one mask register per window, written
// by decoded register-write requests. Reset clears everything, so every
// window starts disabled. Assumes the caller qualifies wr_en.
module pio_window_regs
    import pio_dec_pkg::*;
#(
    parameter int NWIN = NUM_WIN,
    parameter int RW   = DATA_W
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     wr_en,
    input  logic [OFF_W-1:0]         wr_off,
    input  logic [RW-1:0]            wr_data,
    output logic [NWIN-1:0][RW-1:0]  base_q,
    output logic [NWIN-1:0][RW-1:0]  mask_q
);

    for (genvar k = 0; k < NWIN; k++) begin : g_win
        localparam logic [OFF_W-1:0] BOFF = win_base_off(k);
        localparam logic [OFF_W-1:0] MOFF = BOFF + 16'd8;

        // Base register of window k
        always_ff @(posedge clk) begin
            if (!rst_n)                         base_q[k] <= '0;
            else if (wr_en && wr_off == BOFF)   base_q[k] <= wr_data;
        end

        // Mask register of window k
        always_ff @(posedge clk) begin
            if (!rst_n)                         mask_q[k] <= '0;
            else if (wr_en && wr_off == MOFF)   mask_q[k] <= wr_data;
        end
    end

endmodule

// File: rtl/pio_window_match.sv
// Window matcher: masked base compare per window over its own address
// range, qualified by the base enable bit, then a fixed priority in which
// the highest window index wins. Purely combinational.
module pio_window_match
    import pio_dec_pkg::*;
#(
    parameter int NWIN = NUM_WIN,
    parameter int RW   = DATA_W,
    parameter int AW   = ADDR_W
) (
    input  logic [AW-1:0]            addr,
    input  logic [NWIN-1:0][RW-1:0]  base_q,
    input  logic [NWIN-1:0][RW-1:0]  mask_q,
    output logic                     hit,
    output logic [WIN_IW-1:0]        win_sel,
    output logic [RW-1:0]            sel_base
);

    logic [NWIN-1:0] win_hit;

    for (genvar k = 0; k < NWIN; k++) begin : g_cmp
        localparam int LO = win_cmp_lo(k);
        localparam int FW = CMP_HI - LO + 1;
        logic [FW-1:0] a_f, m_f, b_f;
        assign a_f = addr[CMP_HI:LO];
        assign m_f = mask_q[k][CMP_HI:LO];
        assign b_f = base_q[k][CMP_HI:LO];
        assign win_hit[k] = base_q[k][EN_BIT] && ((m_f & a_f) == b_f);
    end

    // Priority pick: scan upward so the last hit overrides earlier ones
    always_comb begin
        hit      = 1'b0;
        win_sel  = '0;
        sel_base = '0;
        for (int k = 0; k < NWIN; k++) begin
            if (win_hit[k]) begin
                hit      = 1'b1;
                win_sel  = WIN_IW'(k);
                sel_base = base_q[k];
            end
        end
        sel_base[EN_BIT] = 1'b0;
    end

endmodule

// File: rtl/pio_cmd_outreg.sv
// Output register: holds one command record behind a valid/ready pair.
// A new command loads only when the slot is empty or being drained; one
// that arrives while stalled is dropped and flagged for one cycle.
module pio_cmd_outreg
    import pio_dec_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     new_cmd,
    input  cmd_rec_t new_rec,
    input  logic     cmd_ready,
    output logic     cmd_valid,
    output cmd_rec_t cmd_rec,
    output logic     overflow_err
);

    logic can_load;
    assign can_load = !cmd_valid || cmd_ready;

    // Valid flag: set on load, cleared when the consumer takes the record
    always_ff @(posedge clk) begin
        if (!rst_n)                    cmd_valid <= 1'b0;
        else if (new_cmd && can_load)  cmd_valid <= 1'b1;
        else if (cmd_ready)            cmd_valid <= 1'b0;
    end

    // Record storage: changes only on load
    always_ff @(posedge clk) begin
        if (!rst_n)                    cmd_rec <= '0;
        else if (new_cmd && can_load)  cmd_rec <= new_rec;
    end

    // Overflow pulse for a command dropped under stall
    always_ff @(posedge clk) begin
        if (!rst_n) overflow_err <= 1'b0;
        else        overflow_err <= new_cmd && !can_load;
    end

endmodule

// File: rtl/pio_region_decoder.sv
// Top: captures requests, routes register writes to the window register
// file, classifies PIO requests by window, works out the transfer length,
// and hands a command record to the output register.
// Assumes at most one request payload per cycle.
module pio_region_decoder
    import pio_dec_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req_vld,
    input  logic [129:0]  req_word,
    input  logic          cmd_ready,
    output logic          cmd_valid,
    output logic [3:0]    cmd_code,
    output logic [39:0]   cmd_addr,
    output logic [7:0]    cmd_len,
    output logic [5:0]    cmd_tid,
    output logic [63:0]   cmd_data,
    output logic [63:0]   cmd_base,
    output logic          nomatch_err,
    output logic          overflow_err
);

    logic              cap_vld;
    logic [REQ_W-1:0]  cap_word;

    pio_req_capture #(.WORD_W(REQ_W)) cap_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .req_vld  (req_vld),
        .req_word (req_word),
        .cap_vld  (cap_vld),
        .cap_word (cap_word)
    );

    // Field extraction
    logic [TYPE_W-1:0] f_type;
    logic [TID_W-1:0]  f_tid;
    logic [SIZE_W-1:0] f_size;
    logic [ADDR_W-1:0] f_addr;
    logic [DATA_W-1:0] f_data;
    logic              is_read;

    assign f_type  = cap_word[TYPE_HI -: TYPE_W];
    assign f_tid   = cap_word[TID_HI  -: TID_W];
    assign f_size  = cap_word[SIZE_HI -: SIZE_W];
    assign f_addr  = cap_word[ADDR_HI -: ADDR_W];
    assign f_data  = cap_word[DATA_HI -: DATA_W];
    assign is_read = (f_type == '0);

    // Routing on upper address bits
    logic is_pio, is_regwr;
    assign is_pio   = cap_vld && (f_addr[ADDR_W-1 -: 4] == 4'hC);
    assign is_regwr = cap_vld && !is_read && (f_addr[ADDR_W-1 -: 8] == 8'h80);

    logic [NUM_WIN-1:0][DATA_W-1:0] base_q, mask_q;

    pio_window_regs #(.NWIN(NUM_WIN), .RW(DATA_W)) regs_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (is_regwr),
        .wr_off  (f_addr[OFF_W-1:0]),
        .wr_data (f_data),
        .base_q  (base_q),
        .mask_q  (mask_q)
    );

    logic              hit;
    logic [WIN_IW-1:0] win_sel;
    logic [DATA_W-1:0] sel_base;

    pio_window_match #(.NWIN(NUM_WIN), .RW(DATA_W), .AW(ADDR_W)) match_i (
        .addr     (f_addr),
        .base_q   (base_q),
        .mask_q   (mask_q),
        .hit      (hit),
        .win_sel  (win_sel),
        .sel_base (sel_base)
    );

    // Command kind from window and, inside config/IO, from address bits
    cmd_kind_e kind;
    always_comb begin
        case (win_sel)
            WIN_IW'(WIN_MEM64): kind = KIND_MEM64;
            WIN_IW'(WIN_MEM32): kind = KIND_MEM32;
            default: begin
                if (f_addr[28])              kind = KIND_IO;
                else if (f_addr[27:20] == 0) kind = KIND_CFG0;
                else                         kind = KIND_CFG1;
            end
        endcase
    end

    // Length: decoded size for reads, raw byte mask for writes
    logic [SIZE_W-1:0] len;
    always_comb begin
        if (!is_read)            len = f_size;
        else if (f_size <= 8'd4) len = SIZE_W'(1) << f_size[2:0];
        else                     len = '0;
    end

    cmd_rec_t new_rec;
    always_comb begin
        new_rec.code = {kind, !is_read};
        new_rec.addr = f_addr;
        new_rec.len  = len;
        new_rec.tid  = f_tid;
        new_rec.data = f_data;
        new_rec.base = sel_base;
    end

    // No-match error pulse for a PIO request that missed every window
    always_ff @(posedge clk) begin
        if (!rst_n) nomatch_err <= 1'b0;
        else        nomatch_err <= is_pio && !hit;
    end

    cmd_rec_t rec_q;

    pio_cmd_outreg out_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .new_cmd      (is_pio && hit),
        .new_rec      (new_rec),
        .cmd_ready    (cmd_ready),
        .cmd_valid    (cmd_valid),
        .cmd_rec      (rec_q),
        .overflow_err (overflow_err)
    );

    assign cmd_code = rec_q.code;
    assign cmd_addr = rec_q.addr;
    assign cmd_len  = rec_q.len;
    assign cmd_tid  = rec_q.tid;
    assign cmd_data = rec_q.data;
    assign cmd_base = rec_q.base;

endmodule

// File: rtl/pio_region_decoder_chk.sv
// Checker: port-level properties of the decoder, bound to the top module.
module pio_region_decoder_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        cmd_ready,
    input logic        cmd_valid,
    input logic [3:0]  cmd_code,
    input logic [39:0] cmd_addr,
    input logic [7:0]  cmd_len,
    input logic [63:0] cmd_data,
    input logic [63:0] cmd_base,
    input logic        nomatch_err,
    input logic        overflow_err
);

    AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid && !cmd_ready |=> cmd_valid && $stable(cmd_code) && $stable(cmd_addr)
                                    && $stable(cmd_data) && $stable(cmd_len)); // R11

    AST_BASE_EN_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid |-> !cmd_base[63]); // R8

    AST_CODE_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid |-> cmd_code <= 4'd9); // R9

    AST_READ_LEN_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid && !cmd_code[0] |-> $onehot0(cmd_len)); // R2

    AST_OVF_ONLY_STALLED: assert property (@(posedge clk) disable iff (!rst_n)
        overflow_err |-> $past(cmd_valid && !cmd_ready)); // R12

    AST_NOMATCH_NO_CMD: assert property (@(posedge clk) disable iff (!rst_n)
        nomatch_err |-> !$rose(cmd_valid)); // R10

endmodule

bind pio_region_decoder pio_region_decoder_chk chk_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .cmd_ready    (cmd_ready),
    .cmd_valid    (cmd_valid),
    .cmd_code     (cmd_code),
    .cmd_addr     (cmd_addr),
    .cmd_len      (cmd_len),
    .cmd_data     (cmd_data),
    .cmd_base     (cmd_base),
    .nomatch_err  (nomatch_err),
    .overflow_err (overflow_err)
);

// File: tb/pio_region_decoder_tb_top.sv
// Scoreboard bench: driver tasks push expected records from a bench-side
// model of the requirements; a monitor pops and compares as records leave.
module pio_region_decoder_tb_top;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req_vld = 1'b0;
    logic [129:0]  req_word = '1;
    logic          cmd_ready = 1'b1;
    logic          cmd_valid;
    logic [3:0]    cmd_code;
    logic [39:0]   cmd_addr;
    logic [7:0]    cmd_len;
    logic [5:0]    cmd_tid;
    logic [63:0]   cmd_data;
    logic [63:0]   cmd_base;
    logic          nomatch_err;
    logic          overflow_err;

    always #10 clk = ~clk;

    pio_region_decoder dut_i (
        .clk(clk), .rst_n(rst_n), .req_vld(req_vld), .req_word(req_word),
        .cmd_ready(cmd_ready), .cmd_valid(cmd_valid), .cmd_code(cmd_code),
        .cmd_addr(cmd_addr), .cmd_len(cmd_len), .cmd_tid(cmd_tid),
        .cmd_data(cmd_data), .cmd_base(cmd_base), .nomatch_err(nomatch_err),
        .overflow_err(overflow_err)
    );

    typedef struct packed {
        logic [3:0]  code;
        logic [39:0] addr;
        logic [7:0]  len;
        logic [5:0]  tid;
        logic [63:0] data;
        logic [63:0] base;
    } exp_t;

    exp_t        q[$];
    int          total = 0, bad = 0;
    int          exp_nm = 0, seen_nm = 0, exp_ov = 0, seen_ov = 0;
    logic [63:0] mb[3];
    logic [63:0] mm[3];

    task automatic check(input string req, input logic [255:0] act, input logic [255:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Monitor: pop and compare on every accepted record, count pulses
    always @(negedge clk) begin
        if (rst_n) begin
            if (cmd_valid && cmd_ready) begin
                if (q.size() == 0) check("R10 unexpected command", 1, 0);
                else begin
                    exp_t e;
                    e = q.pop_front();
                    check("R9 code", cmd_code, e.code);
                    check("R13 record", {cmd_addr, cmd_len, cmd_tid, cmd_data, cmd_base},
                          {e.addr, e.len, e.tid, e.data, e.base});
                end
            end
            if (nomatch_err)  seen_nm++;
            if (overflow_err) seen_ov++;
        end
    end

    task automatic drive_req(input logic [4:0] typ, input logic [5:0] tid,
                             input logic [7:0] sz, input logic [39:0] addr,
                             input logic [63:0] data);
        @(posedge clk); #2 req_vld = 1'b1; req_word = '1;
        @(posedge clk); #2 req_vld = 1'b0;
        req_word = {1'b0, typ, 1'b0, tid, 5'b0, sz, addr, data};
        @(posedge clk); #2 req_word = '1;
    endtask

    // Register write through the block's own space; model follows R3
    task automatic wreg(input logic [15:0] off, input logic [63:0] d);
        drive_req(5'd1, 6'd0, 8'hFF, {8'h80, 16'h0, off}, d);
        case (off)
            16'h2020: mb[0] = d;  16'h2028: mm[0] = d;
            16'h2000: mb[1] = d;  16'h2008: mm[1] = d;
            16'h2010: mb[2] = d;  16'h2018: mm[2] = d;
            default: ;
        endcase
    endtask

    // PIO request: expected record from the requirement model (R2 R5 R6 R7 R8 R9)
    task automatic pio(input logic rd, input logic [5:0] tid, input logic [7:0] sz,
                       input logic [35:0] a36, input logic [63:0] data, input logic drop);
        logic        hit = 1'b0;
        int          w = 0;
        exp_t        e;
        logic [2:0]  kind;
        for (int k = 0; k < 3; k++) begin
            int lo = (k == 0) ? 29 : 24;
            logic [35:0] fm = ~36'h0 << lo;
            if (mb[k][63] && (((mm[k][35:0] & a36) & fm) == (mb[k][35:0] & fm))) begin
                hit = 1'b1; w = k;
            end
        end
        if (w == 2)      kind = 3'd4;
        else if (w == 1) kind = 3'd3;
        else if (a36[28]) kind = 3'd2;
        else kind = (a36[27:20] == 8'h0) ? 3'd0 : 3'd1;
        e.code = {kind, !rd};
        e.addr = {4'hC, a36};
        e.len  = !rd ? sz : (sz <= 8'd4 ? (8'd1 << sz) : 8'd0);
        e.tid  = tid;
        e.data = data;
        e.base = {1'b0, mb[w][62:0]};
        if (!hit) exp_nm++;
        else if (drop) exp_ov++;
        else q.push_back(e);
        drive_req(rd ? 5'd0 : 5'd4, tid, sz, {4'hC, a36}, data);
    endtask

    task automatic idle(input int n);
        repeat (n) @(posedge clk);
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin : main
        logic [39:0] held;
        for (int k = 0; k < 3; k++) begin mb[k] = '0; mm[k] = '0; end
        idle(4);
        @(negedge clk);
        check("R4 reset outputs", {cmd_valid, nomatch_err, overflow_err}, 0);
        @(posedge clk); #2 rst_n = 1'b1;

        // R4: windows disabled after reset
        pio(1'b1, 6'd1, 8'd0, 36'h2_0000_0000, 64'h1, 1'b0);
        idle(3);
        check("R4 nomatch after reset", seen_nm, exp_nm);

        // R3: program the three windows
        wreg(16'h2020, 64'h8000_0000_0000_0000);
        wreg(16'h2028, 64'h0000_000F_E000_0000);
        wreg(16'h2000, 64'h8000_0001_0000_0000);
        wreg(16'h2008, 64'h0000_000F_FF00_0000);
        wreg(16'h2010, 64'h8000_0002_0000_0000);
        wreg(16'h2018, 64'h0000_000F_FF00_0000);
        idle(2);

        // R1: latency from payload cycle to visible command
        pio(1'b1, 6'd5, 8'd3, 36'h0_0000_0040, 64'hAAAA, 1'b0);
        @(negedge clk);
        check("R1 not yet visible", cmd_valid, 0);
        @(negedge clk);
        check("R1 visible two cycles after payload", cmd_valid, 1);
        idle(2);

        // R6: config type 1 write, IO read, bit 28 split
        pio(1'b0, 6'd7, 8'hF0, 36'h0_0010_0000, 64'h1234, 1'b0);
        pio(1'b1, 6'd8, 8'd0, 36'h0_1000_0000, 64'h0, 1'b0);
        pio(1'b1, 6'd9, 8'd1, 36'h0_1FF0_0000, 64'h0, 1'b0);
        // R5: memory windows, compared bits 35:24
        pio(1'b0, 6'd10, 8'h0F, 36'h1_0000_1234, 64'hDEAD_BEEF, 1'b0);
        pio(1'b1, 6'd11, 8'd4, 36'h2_00FF_FFF8, 64'h0, 1'b0);
        // R2: read with out-of-range size gives length 0
        pio(1'b1, 6'd12, 8'd5, 36'h1_0000_0000, 64'h0, 1'b0);
        // R10: miss on every window
        pio(1'b1, 6'd13, 8'd2, 36'h5_0000_0000, 64'h0, 1'b0);
        idle(4);
        check("R10 nomatch count", seen_nm, exp_nm);

        // R7: 64-bit memory window matches all, overrides config
        wreg(16'h2018, 64'h0);
        wreg(16'h2010, 64'h8000_0000_0000_0000);
        pio(1'b1, 6'd14, 8'd2, 36'h0_0000_0080, 64'h0, 1'b0);
        // R7: 32-bit window over config once 64-bit disabled (R5 enable bit)
        wreg(16'h2008, 64'h0);
        wreg(16'h2000, 64'h8000_0000_0000_0000);
        wreg(16'h2010, 64'h0000_0000_0000_0000);
        pio(1'b0, 6'd15, 8'h33, 36'h0_0000_0080, 64'h55, 1'b0);
        wreg(16'h2000, 64'h0);
        pio(1'b1, 6'd16, 8'd1, 36'h0_0000_0080, 64'h0, 1'b0);
        idle(4);
        check("R7 priority records drained", q.size(), 0);

        // R3: writes in the other space and reads in ours change nothing
        drive_req(5'd1, 6'd0, 8'hFF, {8'h88, 16'h0, 16'h2000}, 64'h8000_0000_0000_0000);
        drive_req(5'd0, 6'd0, 8'h00, {8'h80, 16'h0, 16'h2000}, 64'h8000_0000_0000_0000);
        pio(1'b1, 6'd17, 8'd0, 36'h5_0000_0000, 64'h0, 1'b0);
        idle(4);
        check("R3 ignored writes leave window disabled", seen_nm, exp_nm);

        // R11/R12: stall, hold, overflow on second command
        @(posedge clk); #2 cmd_ready = 1'b0;
        pio(1'b1, 6'd20, 8'd3, 36'h0_0000_0100, 64'h0, 1'b0);
        idle(2);
        @(negedge clk);
        held = cmd_addr;
        check("R11 valid under stall", cmd_valid, 1);
        pio(1'b1, 6'd21, 8'd3, 36'h0_0000_0200, 64'h0, 1'b1);
        idle(4);
        @(negedge clk);
        check("R11 held address", cmd_addr, held);
        check("R12 overflow pulses", seen_ov, exp_ov);
        @(posedge clk); #2 cmd_ready = 1'b1;
        idle(6);

        check("R13 scoreboard empty", q.size(), 0);
        check("R10 nomatch final", seen_nm, exp_nm);
        check("R12 overflow final", seen_ov, exp_ov);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule